// File: doc/BRIEF.md
# SPI Serial Clock and Word-Gap Timer

This block is the timing heart of an SPI master. From a fast source clock it derives the serial clock, using a prescale value d that sets each half-period to d+1 source cycles. Beside the clock it produces two one-cycle strobes. The launch strobe tells the shift engine when to drive the next bit. The sample strobe tells it when to capture the incoming bit. After the last bit of each word it counts a fixed idle gap, measured in source-clock cycles, and then tells the engine that the next word may begin.

The engine controls the block with three inputs. `start` opens a transfer and captures the whole configuration. `next_word` launches each later word once the gap has finished. `stop` ends the transfer at once. Clock polarity and the edge used for each direction are set by three configuration bits. The engine sets exactly one of the two edge-select bits. Setting `cfg_rx_neg` gives the phase-1 convention. Setting `cfg_tx_neg` gives the phase-0 convention.

Top module: `sck_gap_timer`

## Requirements
- R1: Once a word begins, `sck` holds its idle level for d+1 cycles. After that it toggles every d+1 cycles, where d is the prescale captured at `start`. A word has 2·B toggles and ends back at the idle level.
- R2: All configuration inputs are captured in the cycle `start` is accepted. Later changes to them have no effect on the running transfer, which includes its gap and its hold.
- R3: `gap_done` pulses exactly 4·G+10 cycles after `word_done`. G is the gap field clamped to the range 1..30, so field 0 acts as 1 (14 cycles) and field 31 acts as 30 (130 cycles).
- R4: `sck` sits at the idle level during the gap and the hold. The idle level is 1 when `cfg_sck_rev`=1 and 0 when it is 0. While no transfer is active, `sck` follows the live `cfg_sck_rev` one cycle later.
- R5: `sample_stb` is high in exactly those cycles where `sck` first shows a new level. With `cfg_rx_neg`=1 this happens on falling transitions only. With `cfg_rx_neg`=0 it happens on rising transitions only.
- R6: `launch_stb` follows the same rule, selected by `cfg_tx_neg`: falling transitions when it is 1, rising transitions when it is 0.
- R7: Each word produces exactly B sample strobes. B is `cfg_bits` clamped to 1..32, so 0 acts as 1. `word_done` pulses for one cycle, in the cycle where `sck` shows the final toggle.
- R8: After `gap_done`, the next word starts only when `next_word` arrives. `start` and `next_word` are ignored at any other time during a transfer.
- R9: `stop` has priority over everything else. In the next cycle `sck` shows the live idle level, and no strobe or done pulse appears, even if the stop cycle coincides with the final edge of a word.
- R10: Under synchronous active-low reset all pulse outputs are low, and `sck` shows the `cfg_sck_rev` level.
- R11: Prescale 0 gives the fastest serial clock, which is half the source clock: `sck` toggles every source cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_prescale | input | PRE_W | Half-period minus one, in source cycles |
| cfg_gap | input | GAP_W | Inter-word gap field |
| cfg_bits | input | BITS_W | Bits per word |
| cfg_sck_rev | input | 1 | Serial clock idles high when set |
| cfg_rx_neg | input | 1 | Sample on falling transitions |
| cfg_tx_neg | input | 1 | Launch on falling transitions |
| start | input | 1 | Open a transfer and capture configuration |
| next_word | input | 1 | Begin the next word after the gap |
| stop | input | 1 | End the transfer immediately |
| sck | output | 1 | Serial clock |
| launch_stb | output | 1 | Drive-next-bit strobe |
| sample_stb | output | 1 | Capture-bit strobe |
| word_done | output | 1 | Final edge of a word |
| gap_done | output | 1 | Gap elapsed; next word may begin |

## Verification
The sharp collision is a `stop` that lands in the same cycle as the final serial-clock edge of a word. In that cycle the edge, the `word_done` pulse and the loading of the gap counter all compete with the abort. The bench computes that cycle from the prescale and the word length, raises `stop` for exactly that edge, and expects an idle clock and no strobe or done pulse afterwards. A second overlap, `start`/`next_word` pulses arriving mid-word together with configuration changes, is judged by checking that every later edge still matches the timing captured at the original `start`.

// File: rtl/sckgen_pkg.sv
// Shared state encoding and helpers for the serial clock / word-gap timer.
// Assumes: nothing beyond plain integer arithmetic.
package sckgen_pkg;

    typedef enum logic [1:0] {
        SG_IDLE = 2'd0,
        SG_RUN  = 2'd1,
        SG_GAP  = 2'd2,
        SG_HOLD = 2'd3
    } sg_state_e;

    // Clamp an integer into [lo, hi].
    function automatic int sg_clamp(input int v, input int lo, input int hi);
        int r;
        r = v;
        if (r < lo) r = lo;
        if (r > hi) r = hi;
        return r;
    endfunction

endpackage

// File: rtl/sg_half_timer.sv
// Half-period counter: produces a one-cycle tick every PERIOD+1 cycles while run is high.
// Assumes: load starts a word (counter loaded with period), period stable while running.
module sg_half_timer #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [PRE_W-1:0] period,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q;

    assign tick = run && (cnt_q == '0);

    // Count down, reloading on every tick so each half-period has the same length.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (load)    cnt_q <= period;
        else if (run)     cnt_q <= (cnt_q == '0) ? period : cnt_q - 1'b1;
    end
endmodule

// File: rtl/sg_gap_timer.sv
// Inter-word gap counter: after load with length L, expire is high L cycles later while enabled.
// Assumes: L >= 1 and en is held for the whole gap.
module sg_gap_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             en,
    input  logic [LEN_W-1:0] len,
    output logic             expire
);
    logic [LEN_W-1:0] cnt_q;

    assign expire = en && (cnt_q == '0);

    // Load length minus one, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load)                 cnt_q <= len - 1'b1;
        else if (en && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/sg_edge_shaper.sv
// Serial clock output stage: toggles on ticks, parks at the idle level otherwise,
// and marks rising or falling transitions with registered strobes aligned to sck.
// Assumes: idle_lvl is the level sck must show when run is low.
module sg_edge_shaper (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic idle_lvl,
    input  logic rx_neg,
    input  logic tx_neg,
    output logic sck,
    output logic sample_stb,
    output logic launch_stb
);
    logic sck_q, samp_q, launch_q;

    // A tick while sck_q is high makes a falling transition; strobes follow the edge selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q    <= idle_lvl;
            samp_q   <= 1'b0;
            launch_q <= 1'b0;
        end else begin
            samp_q   <= run && tick && (sck_q == rx_neg);
            launch_q <= run && tick && (sck_q == tx_neg);
            if (!run)      sck_q <= idle_lvl;
            else if (tick) sck_q <= ~sck_q;
        end
    end

    assign sck        = sck_q;
    assign sample_stb = samp_q;
    assign launch_stb = launch_q;

    // R5: a sample strobe only appears in a cycle where sck has just changed.
    a_r5_sample_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (sck != $past(sck)));

    // R6: a launch strobe only appears in a cycle where sck has just changed.
    a_r6_launch_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        launch_stb |-> (sck != $past(sck)));
endmodule

// File: rtl/sck_gap_timer.sv
// Serial clock and word-gap timer for an SPI master.
// Sequences IDLE -> RUN (one word of 2*B edges) -> GAP (4*G+10 cycles) -> HOLD,
// then RUN again on next_word; stop returns to IDLE from anywhere.
// Assumes: the engine sets at most one edge-select bit; configuration is captured at start.
module sck_gap_timer
    import sckgen_pkg::*;
#(
    parameter int PRE_W     = 8,
    parameter int GAP_W     = 5,
    parameter int BITS_W    = 6,
    parameter int MAX_BITS  = 32,
    parameter int GAP_STEP  = 4,
    parameter int GAP_BASE  = 10,
    parameter int GAP_FMIN  = 1,
    parameter int GAP_FMAX  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRE_W-1:0]  cfg_prescale,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic [BITS_W-1:0] cfg_bits,
    input  logic              cfg_sck_rev,
    input  logic              cfg_rx_neg,
    input  logic              cfg_tx_neg,
    input  logic              start,
    input  logic              next_word,
    input  logic              stop,
    output logic              sck,
    output logic              launch_stb,
    output logic              sample_stb,
    output logic              word_done,
    output logic              gap_done
);
    localparam int EDGE_W = BITS_W + 1;
    localparam int LEN_W  = $clog2(GAP_STEP * GAP_FMAX + GAP_BASE + 1);

    sg_state_e         state_q;
    logic [PRE_W-1:0]  div_l;
    logic [GAP_W-1:0]  gap_l;
    logic [BITS_W-1:0] bits_l;
    logic              pol_l, rxn_l, txn_l;
    logic [EDGE_W-1:0] edge_q;
    logic              word_done_q, gap_done_q;

    logic              in_idle, in_run, in_gap, in_hold;
    logic              go_first, go_next, go_word;
    logic              tick, expire, last_edge, run_edge, idle_lvl;
    logic [PRE_W-1:0]  period;
    logic [LEN_W-1:0]  gap_len;
    logic [BITS_W-1:0] bits_eff;
    logic [GAP_W-1:0]  gap_eff;

    assign in_idle  = (state_q == SG_IDLE);
    assign in_run   = (state_q == SG_RUN);
    assign in_gap   = (state_q == SG_GAP);
    assign in_hold  = (state_q == SG_HOLD);
    assign go_first = in_idle && start && !stop;
    assign go_next  = in_hold && next_word && !stop;
    assign go_word  = go_first || go_next;

    // Prescale comes straight from the input only when a transfer opens.
    assign period   = in_idle ? cfg_prescale : div_l;
    assign bits_eff = BITS_W'(sg_clamp(int'(cfg_bits), 1, MAX_BITS));
    assign gap_eff  = GAP_W'(sg_clamp(int'(cfg_gap), GAP_FMIN, GAP_FMAX));
    assign gap_len  = LEN_W'(GAP_STEP) * LEN_W'(gap_l) + LEN_W'(GAP_BASE);

    assign last_edge = tick && (edge_q == ({bits_l, 1'b0} - EDGE_W'(1)));
    assign run_edge  = in_run && !stop;
    assign idle_lvl  = (in_idle || stop) ? cfg_sck_rev : pol_l;

    // Sequencer and configuration capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SG_IDLE;
            div_l   <= '0;
            gap_l   <= GAP_W'(GAP_FMIN);
            bits_l  <= BITS_W'(1);
            pol_l   <= 1'b0;
            rxn_l   <= 1'b0;
            txn_l   <= 1'b0;
        end else begin
            if (go_first) begin
                div_l  <= cfg_prescale;
                gap_l  <= gap_eff;
                bits_l <= bits_eff;
                pol_l  <= cfg_sck_rev;
                rxn_l  <= cfg_rx_neg;
                txn_l  <= cfg_tx_neg;
            end
            if (stop) begin
                state_q <= SG_IDLE;
            end else begin
                case (state_q)
                    SG_IDLE: if (start)     state_q <= SG_RUN;
                    SG_RUN:  if (last_edge) state_q <= SG_GAP;
                    SG_GAP:  if (expire)    state_q <= SG_HOLD;
                    SG_HOLD: if (next_word) state_q <= SG_RUN;
                    default:                state_q <= SG_IDLE;
                endcase
            end
        end
    end

    // Count serial clock edges within the current word.
    always_ff @(posedge clk) begin
        if (!rst_n)              edge_q <= '0;
        else if (go_word)        edge_q <= '0;
        else if (in_run && tick) edge_q <= edge_q + 1'b1;
    end

    // Registered completion pulses; stop suppresses both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_done_q <= 1'b0;
            gap_done_q  <= 1'b0;
        end else begin
            word_done_q <= run_edge && last_edge;
            gap_done_q  <= in_gap && !stop && expire;
        end
    end

    assign word_done = word_done_q;
    assign gap_done  = gap_done_q;

    sg_half_timer #(.PRE_W(PRE_W)) u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (go_word),
        .run    (in_run),
        .period (period),
        .tick   (tick)
    );

    sg_gap_timer #(.LEN_W(LEN_W)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (run_edge && last_edge),
        .en     (in_gap),
        .len    (gap_len),
        .expire (expire)
    );

    sg_edge_shaper u_shape (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_edge),
        .tick       (tick),
        .idle_lvl   (idle_lvl),
        .rx_neg     (rxn_l),
        .tx_neg     (txn_l),
        .sck        (sck),
        .sample_stb (sample_stb),
        .launch_stb (launch_stb)
    );

    // Assertion support: cycles since the last tick, strobes this word, cycles since word_done.
    logic [PRE_W-1:0]  half_age_q;
    logic [BITS_W-1:0] samp_cnt_q;
    logic [LEN_W-1:0]  gap_age_q;

    // Age of the current half-period in RUN.
    always_ff @(posedge clk) begin
        if (!rst_n || go_word || tick) half_age_q <= '0;
        else if (in_run)               half_age_q <= half_age_q + 1'b1;
    end

    // Sample strobes observed since the word began.
    always_ff @(posedge clk) begin
        if (!rst_n || go_word) samp_cnt_q <= '0;
        else if (sample_stb)   samp_cnt_q <= samp_cnt_q + 1'b1;
    end

    // Saturating distance from the latest word_done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                gap_age_q <= '0;
        else if (word_done)        gap_age_q <= LEN_W'(1);
        else if (gap_age_q != '1)  gap_age_q <= gap_age_q + 1'b1;
    end

    // R1: every tick ends a half-period of exactly d+1 cycles.
    a_r1_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (half_age_q == div_l));

    // R7: a word closes only after B sample strobes.
    a_r7_sample_count: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> ((samp_cnt_q + BITS_W'(sample_stb)) == bits_l));

    // R3: gap length measured from word_done.
    a_r3_gap_length: assert property (@(posedge clk) disable iff (!rst_n)
        gap_done |-> (gap_age_q == gap_len));

    // R4: serial clock parked at the captured idle level when the gap ends.
    a_r4_gap_level: assert property (@(posedge clk) disable iff (!rst_n)
        gap_done |-> (sck == pol_l));

    // R9: stop silences every pulse output in the following cycle.
    a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !(word_done || gap_done || sample_stb || launch_stb));

    // R7: completion pulses never coincide.
    a_r7_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({word_done, gap_done}));
endmodule

// File: tb/test_sck_gap_timer.sv
module test_sck_gap_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_prescale = '0;
    logic [4:0] cfg_gap = '0;
    logic [5:0] cfg_bits = 6'd8;
    logic       cfg_sck_rev = 1'b0;
    logic       cfg_rx_neg = 1'b0;
    logic       cfg_tx_neg = 1'b1;
    logic       start = 1'b0;
    logic       next_word = 1'b0;
    logic       stop = 1'b0;
    logic       sck, launch_stb, sample_stb, word_done, gap_done;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    sck_gap_timer i_sck_gap_timer (
        .clk(clk), .rst_n(rst_n), .cfg_prescale(cfg_prescale), .cfg_gap(cfg_gap),
        .cfg_bits(cfg_bits), .cfg_sck_rev(cfg_sck_rev), .cfg_rx_neg(cfg_rx_neg),
        .cfg_tx_neg(cfg_tx_neg), .start(start), .next_word(next_word), .stop(stop),
        .sck(sck), .launch_stb(launch_stb), .sample_stb(sample_stb),
        .word_done(word_done), .gap_done(gap_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int eff_bits(input int b);
        return (b < 1) ? 1 : ((b > 32) ? 32 : b);
    endfunction

    function automatic int gap_cycles(input int g);
        int f;
        f = (g < 1) ? 1 : ((g > 30) ? 30 : g);
        return 4 * f + 10;
    endfunction

    task automatic quiet_check(input string req, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk(req, "idle sck", sck, cfg_sck_rev);
            chk(req, "sample_stb", sample_stb, 0);
            chk(req, "launch_stb", launch_stb, 0);
            chk(req, "word_done", word_done, 0);
            chk(req, "gap_done", gap_done, 0);
        end
    endtask

    // One transfer of nwords words; stop_n >= 1 aborts the last word at that cycle index.
    task automatic run_xfer(input int d, input int g, input int b, input bit pol,
                            input bit rxn, input bit txn, input int nwords,
                            input int stop_n, input bit poke);
        int eb, gl, wlen, nend, k;
        bit edge_n, exp_sck, fall;
        string rq;
        eb   = eff_bits(b);
        gl   = gap_cycles(g);
        wlen = 2 * eb * (d + 1);
        nend = wlen + gl;
        @(negedge clk);
        cfg_prescale = 8'(d); cfg_gap = 5'(g); cfg_bits = 6'(b);
        cfg_sck_rev = pol; cfg_rx_neg = rxn; cfg_tx_neg = txn;
        start = 1'b1;
        for (int w = 0; w < nwords; w++) begin
            for (int n = 0; n <= nend; n++) begin
                @(negedge clk);
                start = 1'b0;
                next_word = 1'b0;
                if (stop_n >= 1 && w == nwords - 1 && n == stop_n) begin
                    stop = 1'b0;
                    chk("R9", "sck after stop", sck, cfg_sck_rev);
                    chk("R9", "sample after stop", sample_stb, 0);
                    chk("R9", "launch after stop", launch_stb, 0);
                    chk("R9", "word_done after stop", word_done, 0);
                    quiet_check("R9", 6);
                    return;
                end
                k = n / (d + 1);
                edge_n  = (n > 0) && (n <= wlen) && (n % (d + 1) == 0);
                exp_sck = (n <= wlen) ? (pol ^ k[0]) : pol;
                fall    = !exp_sck;
                rq = poke ? "R2/R8" : ((d == 0) ? "R11" : ((n > wlen) ? "R4" : "R1"));
                chk(rq, "sck", sck, exp_sck);
                chk("R5", "sample_stb", sample_stb, edge_n && (fall == rxn));
                chk("R6", "launch_stb", launch_stb, edge_n && (fall == txn));
                chk("R7", "word_done", word_done, n == wlen);
                chk("R3", "gap_done", gap_done, n == nend);
                if (poke && w == 0 && n == wlen / 2) begin
                    cfg_prescale = 8'($urandom_range(0, 255));
                    cfg_gap      = 5'($urandom_range(0, 31));
                    cfg_bits     = 6'($urandom_range(0, 63));
                    cfg_sck_rev  = ~pol;
                    cfg_rx_neg   = ~rxn;
                    cfg_tx_neg   = ~txn;
                end
                if (poke && n == 3) begin
                    start = 1'b1;
                    next_word = 1'b1;
                end
                if (stop_n >= 1 && w == nwords - 1 && n == stop_n - 1) stop = 1'b1;
                else if (n == nend && w < nwords - 1) next_word = 1'b1;
            end
        end
        // Hold after the final gap: nothing moves until next_word or stop.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8", "hold sck", sck, pol);
            chk("R8", "hold sample", sample_stb, 0);
            chk("R8", "hold word_done", word_done, 0);
        end
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R9", "sck after stop in hold", sck, cfg_sck_rev);
        chk("R9", "gap_done after stop", gap_done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R1 watchdog: actual 1 expected 0 (run did not finish)");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int d, g, b, nw, sn, eb;
        bit p, rx;
        void'($urandom(32'd4242));
        // R10: reset with the idle level high.
        cfg_sck_rev = 1'b1;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10", "sck in reset", sck, 1);
        chk("R10", "sample in reset", sample_stb, 0);
        chk("R10", "launch in reset", launch_stb, 0);
        chk("R10", "word_done in reset", word_done, 0);
        chk("R10", "gap_done in reset", gap_done, 0);
        rst_n = 1'b1;
        cfg_sck_rev = 1'b0;
        @(negedge clk);
        chk("R4", "idle sck follows live level", sck, 0);
        quiet_check("R4", 3);

        // Directed: phase-0 and phase-1, both polarities.
        run_xfer(2, 5, 8, 1'b0, 1'b0, 1'b1, 2, -1, 1'b0);
        run_xfer(1, 1, 4, 1'b0, 1'b1, 1'b0, 2, -1, 1'b0);
        run_xfer(0, 30, 3, 1'b1, 1'b0, 1'b1, 2, -1, 1'b0);   // R11 fastest clock
        run_xfer(3, 2, 5, 1'b1, 1'b1, 1'b0, 1, -1, 1'b0);
        // Clamps: gap field 0 and 31, bits 0 and above maximum (R3, R7).
        run_xfer(0, 0, 0, 1'b0, 1'b0, 1'b1, 2, -1, 1'b0);
        run_xfer(0, 31, 40, 1'b0, 1'b1, 1'b0, 1, -1, 1'b0);
        // R2 and R8: config churn and stray start/next_word mid-transfer.
        run_xfer(3, 2, 5, 1'b0, 1'b0, 1'b1, 2, -1, 1'b1);
        // R9: stop on the final edge of the second word, then stop mid-word.
        run_xfer(1, 3, 4, 1'b0, 1'b1, 1'b0, 2, 2 * 4 * 2, 1'b0);
        run_xfer(2, 3, 6, 1'b1, 1'b0, 1'b1, 1, 4, 1'b0);

        // Random mix.
        for (int i = 0; i < 24; i++) begin
            d  = $urandom_range(0, 4);
            g  = $urandom_range(0, 31);
            b  = $urandom_range(0, 40);
            p  = 1'($urandom_range(0, 1));
            rx = 1'($urandom_range(0, 1));
            nw = $urandom_range(1, 3);
            eb = eff_bits(b);
            sn = (i % 5 == 4) ? $urandom_range(1, 2 * eb * (d + 1)) : -1;
            run_xfer(d, g, b, p, rx, ~rx, nw, sn, (i % 4 == 1));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule